// File: doc/BRIEF.md
# Half-Warp Memory Coalescing Unit

This block takes one memory request from a group of sixteen lanes and splits it into as few aligned memory transactions as it can. Each lane brings an active bit and the byte address of one 4-byte word. The unit starts from the lowest-numbered lane that still waits and takes the aligned 128-byte region around that lane's address. It collects every waiting lane that falls inside that region. If all of them fit in one aligned half of the region, the transaction shrinks to 64 bytes, and if they fit in one aligned quarter it shrinks to 32 bytes.

Transactions leave one at a time over a ready/valid handshake. Each one carries an aligned base address, a size code and the mask of the lanes it serves. A new request is taken over a second ready/valid handshake, and only when the unit is idle. After the last transaction, a one-cycle done pulse reports how many transactions the request took. A request with no active lanes gives a done pulse with a count of zero.

Top module: `hw_coalescer`

## Requirements
- R1: While reset is applied and right after it is released, `reqReady` is 1, `txnValid` is 0 and `doneValid` is 0.
- R2: Each transaction covers the aligned 128-byte region that holds the address of the lowest-numbered active lane not yet served. Its mask is exactly the set of unserved active lanes whose addresses fall in that region.
- R3: `txnSize` code 0 means 32 bytes, 1 means 64 bytes and 2 means 128 bytes. The size is 64 when all lanes in the mask share address bit 6, and 32 when they also share bit 5. Otherwise it is 128. `txnBase` is the lead lane's address with the bits below the size cleared.
- R4: Every active lane appears in exactly one transaction mask of its request. Inactive lanes never appear in any mask.
- R5: A request with no active lanes produces no transaction and a done pulse with `doneCount` equal to 0.
- R6: `doneValid` is high for exactly one cycle: the cycle right after the last transaction handshake, or the cycle right after acceptance when there are no transactions. `doneCount` then equals the number of transactions issued.
- R7: While `txnValid` is 1 and `txnReady` is 0, the base, size and mask outputs hold their values and `txnValid` stays 1.
- R8: `reqReady` is 0 from the cycle after a request is accepted up to and including its done cycle. Request inputs that change during that time do not affect the transactions in progress.
- R9: Lanes 0 to 15 at byte addresses 116 + 4*lane give two transactions: first a 32-byte one at base 96 for lanes 0 to 2, then a 64-byte one at base 128 for lanes 3 to 15.
- R10: A pattern that touches k distinct aligned 128-byte regions takes at least k transactions. Sixteen active lanes spaced 128 bytes apart take 16, and sixteen consecutive words aligned to 64 bytes take 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is offered |
| reqReady | output | 1 | Unit is idle and takes the request |
| reqActive | input | LANES | Active bit for each lane |
| reqAddr | input | LANES*ADDR_W | Byte address for each lane; lane i is at bits [i*ADDR_W +: ADDR_W] |
| txnValid | output | 1 | A transaction is presented |
| txnReady | input | 1 | Downstream takes the transaction |
| txnBase | output | ADDR_W | Aligned base address of the transaction |
| txnSize | output | 2 | Size code: 0 = 32 B, 1 = 64 B, 2 = 128 B |
| txnMask | output | LANES | Lanes served by this transaction |
| doneValid | output | 1 | One-cycle pulse when the request is finished |
| doneCount | output | $clog2(LANES+1) | Number of transactions the request took |

## Verification
The two functions that can meet in one cycle are the last transaction handshake of a request and the arrival of the next request. The bench provokes this by keeping `reqValid` high with a second request whose addresses differ from the first, while the first request is still being split under output stalls. The run is judged correct when three things hold. The first request's count and masks must match the addresses latched at acceptance. `reqReady` must stay low until its done pulse. The second request must be taken only in the idle cycle that follows, and must produce its own first transaction from its own addresses.

// File: rtl/coal_pkg.sv
package coal_pkg;

  // Strobes from the control FSM to the datapath.
  typedef struct packed {
    logic load;   // latch a new request
    logic issue;  // current transaction handed off
  } coalCtrl_t;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } coalState_t;

endpackage

// File: rtl/coal_segment_pick.sv
// Combinational choice of the next transaction from the unserved lanes.
module coal_segment_pick #(
  parameter int LANES    = 16,
  parameter int ADDR_W   = 32,
  parameter int SEG_LOG2 = 7,
  parameter int SHRINK   = 2,
  localparam int SIZE_W  = $clog2(SHRINK + 1)
) (
  input  logic [LANES-1:0]        pending,
  input  logic [LANES*ADDR_W-1:0] laneAddrs,
  output logic [ADDR_W-1:0]       segBase,
  output logic [SIZE_W-1:0]       segSize,
  output logic [LANES-1:0]        segMask
);
  localparam int IDX_W    = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int MIN_LOG2 = SEG_LOG2 - SHRINK;

  logic [IDX_W-1:0]  leadIdx;
  logic [ADDR_W-1:0] leadAddr;
  logic [LANES-1:0]  inSeg;
  logic [LANES-1:0]  levelDiff [SHRINK];
  logic              stillTight;

  // Lowest-numbered unserved lane leads.
  always_comb begin
    leadIdx = '0;
    for (int i = LANES - 1; i >= 0; i--) begin
      if (pending[i]) leadIdx = IDX_W'(i);
    end
  end

  assign leadAddr = laneAddrs[leadIdx*ADDR_W +: ADDR_W];

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [ADDR_W-1:0] myAddr;
    assign myAddr   = laneAddrs[g*ADDR_W +: ADDR_W];
    assign inSeg[g] = pending[g] &&
                      (myAddr[ADDR_W-1:SEG_LOG2] == leadAddr[ADDR_W-1:SEG_LOG2]);
    for (genvar l = 0; l < SHRINK; l++) begin : gLevel
      assign levelDiff[l][g] = inSeg[g] &&
                               (myAddr[SEG_LOG2-1-l] != leadAddr[SEG_LOG2-1-l]);
    end
  end

  // Shrink level by level while every covered lane stays in the lead's part.
  always_comb begin
    segSize    = SIZE_W'(SHRINK);
    stillTight = 1'b1;
    for (int l = 0; l < SHRINK; l++) begin
      stillTight = stillTight && !(|levelDiff[l]);
      if (stillTight) segSize = SIZE_W'(SHRINK - 1 - l);
    end
  end

  assign segBase = leadAddr & ({ADDR_W{1'b1}} << (MIN_LOG2 + int'(segSize)));
  assign segMask = inSeg;

endmodule

// File: rtl/coal_datapath.sv
module coal_datapath import coal_pkg::*; #(
  parameter int LANES    = 16,
  parameter int ADDR_W   = 32,
  parameter int SEG_LOG2 = 7,
  parameter int SHRINK   = 2,
  localparam int CNT_W   = $clog2(LANES + 1),
  localparam int SIZE_W  = $clog2(SHRINK + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  coalCtrl_t               ctrl,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  output logic                    pendingEmpty,
  output logic [ADDR_W-1:0]       txnBase,
  output logic [SIZE_W-1:0]       txnSize,
  output logic [LANES-1:0]        txnMask,
  output logic [CNT_W-1:0]        txnCount
);
  logic [LANES-1:0]        pending;
  logic [LANES*ADDR_W-1:0] addrReg;
  logic [CNT_W-1:0]        count;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending <= '0;
      addrReg <= '0;
      count   <= '0;
    end else if (ctrl.load) begin
      pending <= reqActive;
      addrReg <= reqAddr;
      count   <= '0;
    end else if (ctrl.issue) begin
      pending <= pending & ~txnMask;
      count   <= count + 1'b1;
    end
  end

  coal_segment_pick #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2), .SHRINK(SHRINK)
  ) u_pick (
    .pending  (pending),
    .laneAddrs(addrReg),
    .segBase  (txnBase),
    .segSize  (txnSize),
    .segMask  (txnMask)
  );

  assign pendingEmpty = (pending == '0);
  assign txnCount     = count;

  // R4
  served_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.issue |=> (pending & $past(txnMask)) == '0);

  // R5
  empty_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl.load && reqActive == '0) |=> (pendingEmpty && txnCount == '0));

endmodule

// File: rtl/coal_control.sv
module coal_control import coal_pkg::*; (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      txnReady,
  input  logic      pendingEmpty,
  output logic      reqReady,
  output logic      txnValid,
  output logic      doneValid,
  output coalCtrl_t ctrl
);
  coalState_t state, stateNext;

  always_comb begin
    reqReady   = (state == ST_IDLE);
    txnValid   = (state == ST_BUSY) && !pendingEmpty;
    doneValid  = (state == ST_BUSY) && pendingEmpty;
    ctrl.load  = reqReady && reqValid;
    ctrl.issue = txnValid && txnReady;
    stateNext  = state;
    case (state)
      ST_IDLE: if (reqValid) stateNext = ST_BUSY;
      ST_BUSY: if (pendingEmpty) stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  // R6
  done_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R8
  reopen_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> reqReady);

  // R8
  busy_closed_chk: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> !reqReady);

endmodule

// File: rtl/hw_coalescer.sv
module hw_coalescer import coal_pkg::*; #(
  parameter int LANES    = 16,
  parameter int ADDR_W   = 32,
  parameter int SEG_LOG2 = 7,
  parameter int SHRINK   = 2,
  localparam int CNT_W   = $clog2(LANES + 1),
  localparam int SIZE_W  = $clog2(SHRINK + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES-1:0]        reqActive,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  output logic                    txnValid,
  input  logic                    txnReady,
  output logic [ADDR_W-1:0]       txnBase,
  output logic [SIZE_W-1:0]       txnSize,
  output logic [LANES-1:0]        txnMask,
  output logic                    doneValid,
  output logic [CNT_W-1:0]        doneCount
);
  localparam int MIN_LOG2 = SEG_LOG2 - SHRINK;

  coalCtrl_t ctrl;
  logic      pendingEmpty;

  coal_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .txnReady(txnReady),
    .pendingEmpty(pendingEmpty), .reqReady(reqReady), .txnValid(txnValid),
    .doneValid(doneValid), .ctrl(ctrl)
  );

  coal_datapath #(
    .LANES(LANES), .ADDR_W(ADDR_W), .SEG_LOG2(SEG_LOG2), .SHRINK(SHRINK)
  ) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .reqActive(reqActive), .reqAddr(reqAddr),
    .pendingEmpty(pendingEmpty), .txnBase(txnBase), .txnSize(txnSize),
    .txnMask(txnMask), .txnCount(doneCount)
  );

  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> (txnValid && $stable(txnBase) &&
                                 $stable(txnSize) && $stable(txnMask)));

  // R3
  base_align_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnBase & ((ADDR_W'(1) << (MIN_LOG2 + int'(txnSize))) - 1'b1)) == '0));

  // R4
  mask_present_chk: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> txnMask != '0);

endmodule

// File: tb/hw_coalescer_test.sv
module hw_coalescer_test;
  localparam int LANES = 16;
  localparam int AW    = 32;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #10 clk = ~clk;

  logic            reqValid = 1'b0;
  logic            reqReady;
  logic [LANES-1:0] reqActive = '0;
  logic [LANES*AW-1:0] reqAddr = '0;
  logic            txnValid;
  logic            txnReady = 1'b1;
  logic [AW-1:0]   txnBase;
  logic [1:0]      txnSize;
  logic [LANES-1:0] txnMask;
  logic            doneValid;
  logic [4:0]      doneCount;

  hw_coalescer #(.LANES(LANES), .ADDR_W(AW)) uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqActive(reqActive), .reqAddr(reqAddr), .txnValid(txnValid),
    .txnReady(txnReady), .txnBase(txnBase), .txnSize(txnSize),
    .txnMask(txnMask), .doneValid(doneValid), .doneCount(doneCount)
  );

  typedef struct packed {
    logic [15:0] act;
    logic [31:0] base;
    logic [31:0] stride;
    logic [7:0]  cnt;
    logic [31:0] fBase;
    logic [1:0]  fSize;
    logic [15:0] fMask;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{16'hFFFF, 32'd0,    32'd4,   8'd1,  32'd0,    2'd1, 16'hFFFF},
    '{16'hFFFF, 32'd116,  32'd4,   8'd2,  32'd96,   2'd0, 16'h0007},
    '{16'hFFFF, 32'd0,    32'd8,   8'd1,  32'd0,    2'd2, 16'hFFFF},
    '{16'hFFFF, 32'd0,    32'd128, 8'd16, 32'd0,    2'd0, 16'h0001},
    '{16'hFFFF, 32'd256,  32'd0,   8'd1,  32'd256,  2'd0, 16'hFFFF},
    '{16'h00F0, 32'd0,    32'd4,   8'd1,  32'd0,    2'd0, 16'h00F0},
    '{16'h0000, 32'd0,    32'd4,   8'd0,  32'd0,    2'd0, 16'h0000},
    '{16'hFFFF, 32'd64,   32'd4,   8'd1,  32'd64,   2'd1, 16'hFFFF},
    '{16'hFFFF, 32'd32,   32'd4,   8'd1,  32'd0,    2'd2, 16'hFFFF},
    '{16'hFFFF, 32'd0,    32'd36,  8'd5,  32'd0,    2'd2, 16'h000F},
    '{16'h8001, 32'd0,    32'd4,   8'd1,  32'd0,    2'd1, 16'h8001},
    '{16'hAAAA, 32'd0,    32'd4,   8'd1,  32'd0,    2'd1, 16'hAAAA},
    '{16'h0001, 32'd4000, 32'd4,   8'd1,  32'd4000, 2'd0, 16'h0001}
  };

  int total = 0;
  int bad   = 0;

  int gotCount;
  int nTx;
  logic [AW-1:0]    txB [2];
  logic [1:0]       txS [2];
  logic [LANES-1:0] txM [2];
  logic [LANES-1:0] servedAll;
  bit leadOk, subOk, alignOk, busyOk, holdOk, timingOk;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input logic [15:0] act, input logic [31:0] base,
                       input logic [31:0] stride);
    reqActive = act;
    for (int i = 0; i < LANES; i++) reqAddr[i*AW +: AW] = base + i * stride;
  endtask

  task automatic send(input logic [15:0] act, input logic [31:0] base,
                      input logic [31:0] stride);
    @(negedge clk);
    drive(act, base, stride);
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  // Called at the negedge of the first busy cycle; returns at the negedge after done.
  task automatic collect(input logic [15:0] act, input int stall);
    logic [LANES-1:0] left;
    logic [AW-1:0] hB;
    logic [1:0] hS;
    logic [LANES-1:0] hM;
    bit holdPend = 0;
    bit fin = 0;
    int cyc = 0;
    int lastHs = -1;
    servedAll = '0; nTx = 0; gotCount = -1;
    leadOk = 1; subOk = 1; alignOk = 1; busyOk = 1; holdOk = 1; timingOk = 1;
    while (!fin && cyc < 400) begin
      txnReady = (stall == 0) || ((cyc % stall) != 0);
      #1;
      if (holdPend) begin
        if (!txnValid || txnBase != hB || txnSize != hS || txnMask != hM) holdOk = 0;
        holdPend = 0;
      end
      if (txnValid) begin
        int low = -1;
        left = act & ~servedAll;
        for (int i = LANES - 1; i >= 0; i--) if (left[i]) low = i;
        if (reqReady) busyOk = 0;
        if (txnMask == '0 || (txnMask & ~left) != '0) subOk = 0;
        if (low < 0 || !txnMask[low]) leadOk = 0;
        if (txnSize > 2'd2 || (txnBase % (32 << txnSize)) != 0) alignOk = 0;
        if (nTx < 2) begin
          txB[nTx] = txnBase; txS[nTx] = txnSize; txM[nTx] = txnMask;
        end
        if (txnReady) begin
          servedAll |= txnMask; nTx++; lastHs = cyc;
        end else begin
          holdPend = 1; hB = txnBase; hS = txnSize; hM = txnMask;
        end
      end
      if (doneValid) begin
        gotCount = int'(doneCount);
        fin = 1;
        if (reqReady) busyOk = 0;
        if (cyc != lastHs + 1) timingOk = 0;
      end
      cyc++;
      @(negedge clk);
    end
    txnReady = 1'b1;
  endtask

  task automatic judge(input logic [15:0] act, input int expCnt, input int stall);
    chk(gotCount == expCnt, "R6", "count", gotCount, expCnt);
    chk(servedAll == act, "R4", "served lanes", servedAll, act);
    chk(subOk, "R4", "mask within unserved active", 0, 1);
    chk(leadOk, "R2", "lowest unserved lane leads", 0, 1);
    chk(alignOk, "R3", "base aligned to size", 0, 1);
    chk(busyOk, "R8", "reqReady low while busy", 0, 1);
    chk(timingOk, "R6", "done one cycle after last handoff", 0, 1);
    if (stall != 0) chk(holdOk, "R7", "outputs held under stall", 0, 1);
  endtask

  initial begin
    #(20 * 150000);
    bad++; total++;
    $display("FAIL R6 watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(reqReady == 1'b1, "R1", "reqReady in reset", reqReady, 1);
    chk(txnValid == 1'b0, "R1", "txnValid in reset", txnValid, 0);
    chk(doneValid == 1'b0, "R1", "doneValid in reset", doneValid, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(reqReady == 1'b1 && txnValid == 1'b0 && doneValid == 1'b0, "R1",
        "idle after release", {reqReady, txnValid, doneValid}, 3'b100);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      int stall = (v % 3 == 0) ? 0 : (v % 3) + 1;
      send(VECS[v].act, VECS[v].base, VECS[v].stride);
      collect(VECS[v].act, stall);
      judge(VECS[v].act, int'(VECS[v].cnt), stall);
      if (VECS[v].cnt == 0) begin
        chk(nTx == 0 && gotCount == 0, "R5", "empty request", nTx, 0);
      end else begin
        chk(txB[0] == VECS[v].fBase, "R2", "first base", txB[0], VECS[v].fBase);
        chk(txS[0] == VECS[v].fSize, "R3", "first size", txS[0], VECS[v].fSize);
        chk(txM[0] == VECS[v].fMask, "R2", "first mask", txM[0], VECS[v].fMask);
      end
    end

    // R9: worked example, second transaction
    send(16'hFFFF, 32'd116, 32'd4);
    collect(16'hFFFF, 0);
    chk(nTx == 2, "R9", "transactions", nTx, 2);
    chk(txB[0] == 32'd96 && txS[0] == 2'd0 && txM[0] == 16'h0007, "R9",
        "first txn", {txB[0], txS[0], txM[0]}, {32'd96, 2'd0, 16'h0007});
    chk(txB[1] == 32'd128 && txS[1] == 2'd1 && txM[1] == 16'hFFF8, "R9",
        "second txn", {txB[1], txS[1], txM[1]}, {32'd128, 2'd1, 16'hFFF8});

    // R10: scattered vs contiguous
    send(16'hFFFF, 32'd1024, 32'd128);
    collect(16'hFFFF, 0);
    chk(gotCount == 16, "R10", "stride 128 count", gotCount, 16);
    send(16'hFFFF, 32'd192, 32'd4);
    collect(16'hFFFF, 2);
    chk(gotCount == 1 && txS[0] == 2'd1, "R10", "aligned 64B count", gotCount, 1);

    // R8: next request waits while the current one finishes
    @(negedge clk);
    drive(16'hFFFF, 32'd0, 32'd128);
    reqValid = 1'b1;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    drive(16'h0001, 32'd4000, 32'd4);   // held offer of the next request
    collect(16'hFFFF, 2);
    judge(16'hFFFF, 16, 2);
    chk(reqReady == 1'b1, "R8", "idle after done", reqReady, 1);
    @(negedge clk);
    reqValid = 1'b0;
    collect(16'h0001, 0);
    chk(gotCount == 1, "R8", "second request count", gotCount, 1);
    chk(txB[0] == 32'd4000 && txM[0] == 16'h0001 && txS[0] == 2'd0, "R8",
        "second request txn", {txB[0], txM[0]}, {32'd4000, 16'h0001});

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule